// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block searches and grows a singly linked chain of 32-bit capability headers kept in a 4 KB configuration memory. It owns no storage of its own. It reaches the memory through a synchronous port that performs one word access per cycle, with read data returned on the cycle after the request. Every header packs a 16-bit identifier, a 4-bit version and a 12-bit byte offset to the next header. The chain always begins at a fixed base offset, 0x100 by default.

A lookup command takes an identifier and follows the links from the base. It reports the offset of the header whose identifier matches, together with the offset of the header visited just before it. Identifier zero is reserved and never matches, so looking it up returns the offset of the last header in the chain.

An append command places a new header at a caller-chosen offset. At the base offset, the existing link is kept. Anywhere else, the block first finds the tail, then rewrites the tail's link field to point at the new offset, then writes the new header as the last entry. Broken chains and bad append arguments end the command with an error flag. Broken chains include misaligned or out-of-range links and chains that never terminate.

Top module: `ecw_walker`

## Requirements
- R1: A header word holds the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20; a next offset of zero ends the chain.
- R2: If the word at the base offset is all zero, a lookup finishes with found offset 0, previous offset 0 and no error.
- R3: A lookup stops at the first header whose identifier equals the requested non-zero identifier and returns that header's offset as found and the offset of the header read before it as previous (0 when the match is at the base).
- R4: A lookup that reaches a header with next offset 0 without matching returns found 0 and previous equal to that last header's offset, without error.
- R5: Identifier 0 never matches, so a lookup of 0 on a non-empty chain returns found 0 and the tail offset as previous.
- R6: A next offset that is not a multiple of 4, is below the base offset or is above 4088 ends the command with the error flag set and no memory write; only offsets passing these rules are ever read.
- R7: A walk that would read more than MAX_HOPS (default 1024) headers ends with the error flag set and no memory write.
- R8: Appending at the base offset reads the base word and rewrites it with the new identifier and version while keeping its existing next offset; results are found = base, previous = 0.
- R9: Appending at any other offset rewrites only bits 31:20 of the tail header to the new offset, then writes the new header with next offset 0 at that offset; results are found = new offset, previous = tail offset.
- R10: An append whose size is below 8, whose offset is below the base or not a multiple of 4, or whose offset plus size is not below 4096, or a non-base append on an empty chain, ends with the error flag set and no memory write.
- R11: Busy is high from the cycle after an accepted start up to and including the one-cycle done pulse; results are valid on the done cycle; a start seen while busy is ignored.
- R12: The memory port never requests a read and a write in the same cycle, and read data is consumed the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken while idle |
| op_append | input | 1 | 1 = append, 0 = lookup |
| cap_id | input | 16 | Identifier to find or to write |
| cap_ver | input | 4 | Version written by an append |
| app_off | input | 12 | Byte offset of the appended header |
| app_size | input | 13 | Byte size of the appended capability |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found_off | output | 12 | Matching or appended header offset, 0 if none |
| prev_off | output | 12 | Offset of the preceding header, or tail |
| err | output | 1 | Command ended on a broken chain or bad arguments |
| mem_addr | output | 10 | Word address to configuration memory |
| mem_rd_en | output | 1 | Read request |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |

## Verification
Lookups run over chains of one to six headers scattered out of address order. Every member is looked up, and so are one absent identifier and identifier zero. This separates hits at the head, in the middle and at the tail from the fall-through tail report. Chains with links that are misaligned, too low, too high, or exactly at the highest legal offset separate rejected links from the accepted boundary. A two-node loop exercises the hop limit. Appends are tried at the base (empty and populated), at interior offsets, at the last legal offset and with each kind of bad argument. The memory image is compared bit by bit, which shows that only the link field of the tail changes.

// File: rtl/ecw_pkg.sv
`timescale 1ns/1ps
package ecw_pkg;
  localparam int OFF_W   = 12;
  localparam int ID_W    = 16;
  localparam int VER_W   = 4;
  localparam int WORD_W  = OFF_W + VER_W + ID_W;
  localparam int WADDR_W = OFF_W - 2;
  localparam int SIZE_W  = OFF_W + 1;
  localparam int MEM_BYTES = 1 << OFF_W;

  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [ID_W-1:0]   id_t;
  typedef logic [VER_W-1:0]  ver_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam off_t LAST_HDR = off_t'(MEM_BYTES - 8);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_EVAL, ST_BASEWR, ST_PATCH, ST_NEWWR, ST_DONE
  } st_t;

  function automatic id_t hdr_id(input word_t w);
    return w[ID_W-1:0];
  endfunction

  function automatic off_t hdr_next(input word_t w);
    return w[WORD_W-1 -: OFF_W];
  endfunction

  function automatic word_t hdr_pack(input id_t id, input ver_t ver, input off_t nxt);
    return {nxt, ver, id};
  endfunction

  // replace the link field, keep identifier and version bits
  function automatic word_t hdr_relink(input logic [ID_W+VER_W-1:0] body, input off_t nxt);
    return {nxt, body};
  endfunction

  function automatic logic link_ok(input off_t off, input off_t base);
    return (off >= base) && (off <= LAST_HDR) && (off[1:0] == 2'b00);
  endfunction

  function automatic logic app_ok(input off_t off, input logic [SIZE_W-1:0] size, input off_t base);
    logic [OFF_W+1:0] fin;
    fin = (OFF_W+2)'(off) + (OFF_W+2)'(size);
    return (size >= SIZE_W'(8)) && (off >= base) && (off[1:0] == 2'b00) &&
           (fin < (OFF_W+2)'(MEM_BYTES));
  endfunction
endpackage

// File: rtl/ecw_link_check.sv
`timescale 1ns/1ps
module ecw_link_check
  import ecw_pkg::*;
(
  input  word_t word,
  input  id_t   want_id,
  input  off_t  base,
  output logic  hit,
  output logic  last,
  output logic  bad,
  output logic  blank,
  output off_t  nxt
);
  always_comb begin
    nxt   = hdr_next(word);
    blank = (word == '0);
    hit   = (want_id != '0) && (hdr_id(word) == want_id);
    last  = (nxt == '0);
    bad   = !link_ok(nxt, base);
  end
endmodule

// File: rtl/ecw_hop_counter.sv
`timescale 1ns/1ps
module ecw_hop_counter #(
  parameter int MAX_HOPS = 1024,
  parameter int CW = $clog2(MAX_HOPS + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  localparam logic [CW-1:0] LAST_STEP = CW'(MAX_HOPS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // the header being evaluated now is the last one allowed
  assign at_limit = (count == LAST_STEP);
endmodule

// File: rtl/ecw_walker.sv
`timescale 1ns/1ps
module ecw_walker
  import ecw_pkg::*;
#(
  parameter off_t BASE_OFF = 12'h100,
  parameter int   MAX_HOPS = 1024,
  localparam int  CW = $clog2(MAX_HOPS + 1)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_append,
  input  logic [ID_W-1:0]    cap_id,
  input  logic [VER_W-1:0]   cap_ver,
  input  logic [OFF_W-1:0]   app_off,
  input  logic [SIZE_W-1:0]  app_size,
  output logic               busy,
  output logic               done,
  output logic [OFF_W-1:0]   found_off,
  output logic [OFF_W-1:0]   prev_off,
  output logic               err,
  output logic [WADDR_W-1:0] mem_addr,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata
);
  st_t   st_q;
  off_t  cur_q, prv_q, off_q;
  word_t hdr_q;
  id_t   id_q;
  ver_t  ver_q;
  logic  app_q;
  off_t  res_found_q, res_prev_q;
  logic  res_err_q;

  id_t   walk_id;
  logic  hit, last, bad, blank;
  off_t  nxt;
  logic  [CW-1:0] hop_cnt;
  logic  at_limit;
  logic  args_ok;

  // named events for the checker
  logic in_eval, ev_base_app, ev_empty, walk_eval;
  logic ev_match, ev_tail, ev_bad_link, ev_hop_stop, ev_advance;

  assign walk_id = app_q ? '0 : id_q;
  assign args_ok = app_ok(app_off, app_size, BASE_OFF);

  ecw_link_check u_link (
    .word    (mem_rdata),
    .want_id (walk_id),
    .base    (BASE_OFF),
    .hit     (hit),
    .last    (last),
    .bad     (bad),
    .blank   (blank),
    .nxt     (nxt)
  );

  ecw_hop_counter #(.MAX_HOPS(MAX_HOPS), .CW(CW)) u_hops (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (st_q == ST_IDLE),
    .step     (st_q == ST_EVAL),
    .count    (hop_cnt),
    .at_limit (at_limit)
  );

  always_comb begin
    in_eval     = (st_q == ST_EVAL);
    ev_base_app = in_eval && app_q && (off_q == BASE_OFF);
    ev_empty    = in_eval && !ev_base_app && (cur_q == BASE_OFF) && blank;
    walk_eval   = in_eval && !ev_base_app && !ev_empty;
    ev_match    = walk_eval && hit;
    ev_tail     = walk_eval && !hit && last;
    ev_bad_link = walk_eval && !hit && !last && bad;
    ev_hop_stop = walk_eval && !hit && !last && !bad && at_limit;
    ev_advance  = walk_eval && !hit && !last && !bad && !at_limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      prv_q       <= '0;
      off_q       <= '0;
      hdr_q       <= '0;
      id_q        <= '0;
      ver_q       <= '0;
      app_q       <= 1'b0;
      res_found_q <= '0;
      res_prev_q  <= '0;
      res_err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          id_q        <= cap_id;
          ver_q       <= cap_ver;
          off_q       <= app_off;
          app_q       <= op_append;
          cur_q       <= BASE_OFF;
          prv_q       <= '0;
          res_found_q <= '0;
          res_prev_q  <= '0;
          res_err_q   <= 1'b0;
          if (op_append && !args_ok) begin
            res_err_q <= 1'b1;
            st_q      <= ST_DONE;
          end else begin
            st_q <= ST_RD;
          end
        end
        ST_RD: st_q <= ST_EVAL;
        ST_EVAL: begin
          hdr_q <= mem_rdata;
          if (ev_base_app) begin
            st_q <= ST_BASEWR;
          end else if (ev_empty) begin
            res_err_q <= app_q;
            st_q      <= ST_DONE;
          end else if (ev_match) begin
            res_found_q <= cur_q;
            res_prev_q  <= prv_q;
            st_q        <= ST_DONE;
          end else if (ev_tail) begin
            res_prev_q <= cur_q;
            st_q       <= app_q ? ST_PATCH : ST_DONE;
          end else if (ev_bad_link || ev_hop_stop) begin
            res_err_q <= 1'b1;
            st_q      <= ST_DONE;
          end else begin
            prv_q <= cur_q;
            cur_q <= nxt;
            st_q  <= ST_RD;
          end
        end
        ST_BASEWR: begin
          res_found_q <= BASE_OFF;
          st_q        <= ST_DONE;
        end
        ST_PATCH: st_q <= ST_NEWWR;
        ST_NEWWR: begin
          res_found_q <= off_q;
          st_q        <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd_en = (st_q == ST_RD);
    mem_wr_en = (st_q == ST_BASEWR) || (st_q == ST_PATCH) || (st_q == ST_NEWWR);
    mem_addr  = cur_q[OFF_W-1:2];
    mem_wdata = '0;
    unique case (st_q)
      ST_BASEWR: begin
        mem_addr  = BASE_OFF[OFF_W-1:2];
        mem_wdata = hdr_pack(id_q, ver_q, hdr_next(hdr_q));
      end
      ST_PATCH: begin
        mem_addr  = cur_q[OFF_W-1:2];
        mem_wdata = hdr_relink(hdr_q[ID_W+VER_W-1:0], off_q);
      end
      ST_NEWWR: begin
        mem_addr  = off_q[OFF_W-1:2];
        mem_wdata = hdr_pack(id_q, ver_q, '0);
      end
      default: ;
    endcase
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign found_off = res_found_q;
  assign prev_off  = res_prev_q;
  assign err       = res_err_q;
endmodule

// File: rtl/ecw_walker_chk.sv
`timescale 1ns/1ps
module ecw_walker_chk
  import ecw_pkg::*;
#(
  parameter off_t BASE_OFF = 12'h100,
  parameter int   MAX_HOPS = 1024,
  parameter int   CW = $clog2(MAX_HOPS + 1)
)(
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [OFF_W-1:0]   found_off,
  input logic               mem_rd_en,
  input logic               mem_wr_en,
  input logic [WADDR_W-1:0] mem_addr,
  input logic [CW-1:0]      hop_cnt,
  input logic               ev_match,
  input logic               ev_bad_link,
  input logic               ev_hop_stop
);
  localparam logic [WADDR_W-1:0] BASE_W = BASE_OFF[OFF_W-1:2];

  AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R12
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R11
  AST_BAD_LINK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_link |=> (done && err && !mem_wr_en)); // R6
  AST_READ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr >= BASE_W)); // R6
  AST_HOP_STOP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hop_stop |=> (done && err && !mem_wr_en)); // R7
  AST_HOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hop_cnt <= CW'(MAX_HOPS)); // R7
  AST_MATCH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> (done && !err && found_off >= BASE_OFF && found_off[1:0] == 2'b00)); // R3
endmodule

bind ecw_walker ecw_walker_chk #(.BASE_OFF(BASE_OFF), .MAX_HOPS(MAX_HOPS), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .found_off   (found_off),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .mem_addr    (mem_addr),
  .hop_cnt     (hop_cnt),
  .ev_match    (ev_match),
  .ev_bad_link (ev_bad_link),
  .ev_hop_stop (ev_hop_stop)
);

// File: tb/test_ecw_walker.sv
`timescale 1ns/1ps
module test_ecw_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        start = 1'b0, op_append = 1'b0;
  logic [15:0] cap_id = '0;
  logic [3:0]  cap_ver = '0;
  logic [11:0] app_off = '0;
  logic [12:0] app_size = '0;
  logic        busy, done, err;
  logic [11:0] found_off, prev_off;
  logic [9:0]  mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_wdata, rdq;

  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0, tb_clr = 1'b0;
  logic [9:0]  tb_waddr = '0;
  logic [31:0] tb_wdata = '0;
  int wr_cnt = 0, both_cnt = 0;
  int nchk = 0, nerr = 0;
  logic [11:0] r_found, r_prev;
  logic        r_err;

  ecw_walker i_ecw_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .op_append(op_append),
    .cap_id(cap_id), .cap_ver(cap_ver), .app_off(app_off), .app_size(app_size),
    .busy(busy), .done(done), .found_off(found_off), .prev_off(prev_off), .err(err),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(rdq)
  );

  // registered-read configuration memory model
  always @(posedge clk) begin
    if (tb_clr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (tb_we) begin
      mem[tb_waddr] <= tb_wdata;
    end else if (mem_wr_en) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd_en) rdq <= mem[mem_addr];
    if (mem_rd_en && mem_wr_en) both_cnt <= both_cnt + 1;
  end

  // R1 layout: next in 31:20, version in 19:16, identifier in 15:0
  function automatic logic [31:0] mkhdr(int id, int ver, int nxt);
    return 32'(longint'(nxt) * 1048576 + longint'(ver) * 65536 + longint'(id));
  endfunction

  function automatic int loc(int k);
    return (k == 0) ? 256 : 256 + (((k * 7) % 11) + 1) * 32;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(int off, logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = 10'(off / 4); tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic wipe();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic run(bit app, int id, int ver, int off, int size);
    @(negedge clk);
    op_append = app; cap_id = 16'(id); cap_ver = 4'(ver);
    app_off = 12'(off); app_size = 13'(size); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    r_found = found_off; r_prev = prev_off; r_err = err;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    chk("R11", "reset busy", busy, 0);
    chk("R11", "reset done", done, 0);
    chk("R12", "reset port idle", {mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;

    // chains of 1..6 headers, out of address order
    for (int n = 1; n <= 6; n++) begin
      wipe();
      for (int k = 0; k < n; k++)
        poke(loc(k), mkhdr(16'h1000 + n * 16 + k, k, (k == n - 1) ? 0 : loc(k + 1)));
      for (int k = 0; k < n; k++) begin
        run(0, 16'h1000 + n * 16 + k, 0, 0, 0);
        chk("R3", "found", r_found, loc(k));
        chk("R3", "prev", r_prev, (k == 0) ? 0 : loc(k - 1));
        chk("R3", "err", r_err, 0);
      end
      run(0, 16'hBEEF, 0, 0, 0);
      chk("R4", "absent found", r_found, 0);
      chk("R4", "absent prev", r_prev, loc(n - 1));
      chk("R4", "absent err", r_err, 0);
      run(0, 0, 0, 0, 0);
      chk("R5", "id0 found", r_found, 0);
      chk("R5", "id0 tail", r_prev, loc(n - 1));
    end

    // empty chain
    wipe();
    run(0, 1, 0, 0, 0);
    chk("R2", "empty found", r_found, 0);
    chk("R2", "empty prev", r_prev, 0);
    chk("R2", "empty err", r_err, 0);
    w0 = wr_cnt;
    run(1, 16'h66, 1, 12'h300, 16);
    chk("R10", "append on empty err", r_err, 1);
    chk("R10", "append on empty writes", wr_cnt - w0, 0);

    run(1, 16'h11, 2, 12'h100, 16);
    chk("R8", "base append found", r_found, 12'h100);
    chk("R8", "base append prev", r_prev, 0);
    chk("R1", "base header image", mem[64], mkhdr(16'h11, 2, 0));

    // base append keeps the existing link
    poke(12'h100, mkhdr(16'h22, 1, 12'h200));
    poke(12'h200, mkhdr(16'h33, 1, 0));
    run(1, 16'h44, 5, 12'h100, 8);
    chk("R8", "base link kept", mem[64], mkhdr(16'h44, 5, 12'h200));
    chk("R8", "base err", r_err, 0);

    // append at an interior offset
    w0 = wr_cnt;
    run(1, 16'h55, 3, 12'h300, 32);
    chk("R9", "found", r_found, 12'h300);
    chk("R9", "prev tail", r_prev, 12'h200);
    chk("R9", "tail relinked", mem[128], mkhdr(16'h33, 1, 12'h300));
    chk("R9", "new header", mem[192], mkhdr(16'h55, 3, 0));
    chk("R9", "write count", wr_cnt - w0, 2);
    run(0, 16'h55, 0, 0, 0);
    chk("R3", "find appended", r_found, 12'h300);
    chk("R3", "find appended prev", r_prev, 12'h200);

    // bad append arguments
    w0 = wr_cnt;
    run(1, 16'h77, 0, 12'h400, 4);
    chk("R10", "size 4 err", r_err, 1);
    run(1, 16'h77, 0, 12'h0F0, 16);
    chk("R10", "low offset err", r_err, 1);
    run(1, 16'h77, 0, 12'h402, 16);
    chk("R10", "misaligned err", r_err, 1);
    run(1, 16'h77, 0, 12'hFF8, 8);
    chk("R10", "end at 4096 err", r_err, 1);
    chk("R10", "no writes", wr_cnt - w0, 0);
    run(1, 16'h78, 1, 12'hFF0, 8);
    chk("R10", "last legal append err", r_err, 0);
    chk("R10", "last legal found", r_found, 12'hFF0);
    chk("R9", "last legal prev", r_prev, 12'h300);
    chk("R9", "new at top", mem[1020], mkhdr(16'h78, 1, 0));

    // broken links
    wipe();
    w0 = wr_cnt;
    poke(12'h100, mkhdr(1, 0, 12'h102));
    run(0, 9, 0, 0, 0);
    chk("R6", "misaligned link err", r_err, 1);
    poke(12'h100, mkhdr(1, 0, 12'h080));
    run(0, 9, 0, 0, 0);
    chk("R6", "low link err", r_err, 1);
    poke(12'h100, mkhdr(1, 0, 12'hFFC));
    run(0, 9, 0, 0, 0);
    chk("R6", "high link err", r_err, 1);
    run(1, 9, 0, 12'h300, 16);
    chk("R6", "append over bad link err", r_err, 1);
    chk("R6", "no writes", wr_cnt - w0, 0);
    poke(12'h100, mkhdr(1, 0, 12'hFF8));
    poke(12'hFF8, mkhdr(7, 0, 0));
    run(0, 7, 0, 0, 0);
    chk("R6", "top link accepted", r_found, 12'hFF8);
    chk("R6", "top link prev", r_prev, 12'h100);
    chk("R6", "top link err", r_err, 0);

    // handshake on a short lookup
    @(negedge clk);
    op_append = 1'b0; cap_id = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "busy after start", busy, 1);
    chk("R11", "no early done", done, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R11", "done pulse ends", done, 0);
    chk("R11", "idle after done", busy, 0);

    // loop 0x100 <-> 0x200 and a start during the walk
    wipe();
    poke(12'h100, mkhdr(1, 0, 12'h200));
    poke(12'h200, mkhdr(2, 0, 12'h100));
    w0 = wr_cnt;
    @(negedge clk);
    op_append = 1'b0; cap_id = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    op_append = 1'b1; cap_id = 16'h99; app_off = 12'h300; app_size = 13'd16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R7", "hop limit err", err, 1);
    repeat (4) @(negedge clk);
    chk("R11", "start while busy ignored", busy, 0);
    chk("R11", "ignored start wrote nothing", wr_cnt - w0, 0);
    chk("R11", "loop image intact", mem[64], mkhdr(1, 0, 12'h200));
    run(1, 16'h99, 0, 12'h300, 16);
    chk("R7", "append on loop err", r_err, 1);
    chk("R7", "append on loop no writes", wr_cnt - w0, 0);

    chk("R12", "read and write together", both_cnt, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule